// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts oscillator cycles and asks the chip for a reset unless software proves it is alive. Software proves this by writing a two-byte key to a write-only service register: one or more writes of 0x55, then one write of 0xAA. The closing 0xAA puts the count back to zero. If the count reaches the selected timeout first, the block issues a one-cycle reset request.

An 8-bit control register picks one of seven timeouts, or turns the counter off. It can also turn on window mode. In window mode, servicing too early is itself a fault: software must service inside the last quarter of the period. A further bit freezes the count while an external debug-active input is high. In user mode the window and rate fields take only the first write after reset. A special-mode input lifts that limit. The freeze bit locks after its first write in either mode.

For a short simulation, the `EXP_OFFSET` parameter lowers every timeout exponent by the same amount. With the default of 0, the timeouts are 2^14 to 2^24 cycles.

Top module: `wdog_win`

## Requirements
- R1: After reset the control register reads 0x00, `rst_req` is low, and with the rate field at 0 no reset request ever occurs.
- R2: The control register is at address `CTRL_ADDR` (default 0). Bit 7 is window enable, bit 6 is debug-freeze enable, bits 2:0 are the rate code, and bits 5:3 read as 0. The service register is at `SVC_ADDR` (default 1) and reads as 0x00.
- R3: Rate codes 1 to 7 select timeouts of 2^E cycles, with E = 14, 16, 18, 20, 22, 23, 24 minus `EXP_OFFSET`. `rst_req` goes high exactly 2^E clock edges after the edge that accepted the rate write.
- R4: In user mode (`special_mode` = 0) the window and rate fields take only the first control write after reset. In special mode they take every write.
- R5: The debug-freeze bit takes only the first control write after reset, in either mode.
- R6: While the freeze bit is 1 and `dbg_active` is 1, the count holds its value. With the freeze bit at 0, `dbg_active` has no effect.
- R7: `rst_req` is a single-cycle registered pulse. The count restarts from zero at that pulse, so a watchdog that is never serviced fires once every period.
- R8: Any number of 0x55 writes followed by one 0xAA write to the service register restarts the count from zero. The next timeout then comes one full period after the 0xAA edge.
- R9: A service write of any value other than 0x55 or 0xAA gives `rst_req` on the next cycle. So does an 0xAA write with no 0x55 before it.
- R10: With window enable set and a nonzero rate, a service write made while the count is below 3·2^(E-2) gives `rst_req` on the next cycle. A write at or above that count is accepted. After a restart, the next window has to be waited for again.
- R11: After a reset request the key tracker is idle, so an 0xAA write then needs a new 0x55 before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| special_mode | input | 1 | 1 = control fields may be rewritten |
| dbg_active | input | 1 | Debugger is halting the system |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench sweeps all seven rate codes with the exponent offset at 10. For each code it checks that the pulse lands on the exact edge and not one cycle earlier, then checks that a second pulse follows one period later, which separates an off-by-one in the compare from a missing counter clear. The service path is tried with repeated 0x55 bytes, with stray values, with 0xAA alone, and with 0xAA after a fault, which separates the value check from the tracker state. Window mode is probed at the count just below the window start and at the window start itself, then again right after a restart. The freeze input is applied with the freeze bit set and with it clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned RATE_W   = 3;
   localparam int unsigned NUM_RATE = 7;
   localparam int unsigned EXP_MAX  = 24;
   localparam int unsigned WIN_BIT  = 7;
   localparam int unsigned FRZ_BIT  = 6;

   localparam logic [7:0] KEY_ARM  = 8'h55;
   localparam logic [7:0] KEY_FIRE = 8'hAA;

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_e;

   // timeout exponent for each rate code; steps are uneven at the top
   function automatic int unsigned rate_exp(input int unsigned code);
      case (code)
         1:       return 14;
         2:       return 16;
         3:       return 18;
         4:       return 20;
         5:       return 22;
         6:       return 23;
         7:       return 24;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [7:0]        wdata,
   input  logic              special,
   output logic              win_en,
   output logic              frz_en,
   output logic [RATE_W-1:0] rate,
   output logic              rate_wr
);

   logic main_lock;
   logic frz_lock;

   assign rate_wr = wr_stb && (special || !main_lock);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_en    <= 1'b0;
         frz_en    <= 1'b0;
         rate      <= '0;
         main_lock <= 1'b0;
         frz_lock  <= 1'b0;
      end else if (wr_stb) begin
         if (rate_wr) begin
            win_en <= wdata[WIN_BIT];
            rate   <= wdata[RATE_W-1:0];
         end
         if (!special) begin
            main_lock <= 1'b1;
         end
         if (!frz_lock) begin
            frz_en   <= wdata[FRZ_BIT];
            frz_lock <= 1'b1;
         end
      end
   end

   // R4: a user-mode write after the first leaves window and rate unchanged
   a_r4_user_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !special && main_lock) |=> ($stable(rate) && $stable(win_en)));

   // R5: once locked, the freeze bit never moves again
   a_r5_frz_once: assert property (@(posedge clk) disable iff (!rst_n)
      frz_lock |=> $stable(frz_en));

endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [7:0] wdata,
   input  logic       win_ok,
   input  logic       tmo,
   output logic       restart,
   output logic       fault
);

   seq_e state;
   logic is_arm;
   logic is_fire;

   assign is_arm  = (wdata == KEY_ARM);
   assign is_fire = (wdata == KEY_FIRE);

   always_comb begin
      fault = 1'b0;
      if (wr_stb) begin
         if (!win_ok || !(is_arm || is_fire)) begin
            fault = 1'b1;
         end else if (is_fire && state == SEQ_IDLE) begin
            fault = 1'b1;
         end
      end
   end

   assign restart = wr_stb && !fault && is_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
      end else if (tmo || fault) begin
         state <= SEQ_IDLE;
      end else if (wr_stb) begin
         state <= is_arm ? SEQ_ARMED : SEQ_IDLE;
      end
   end

   // R11: any fault leaves the tracker idle
   a_r11_idle_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (state == SEQ_IDLE));

   // R8: the tracker arms only on an accepted 0x55 write
   a_r8_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == SEQ_ARMED) |-> $past(wr_stb && wdata == KEY_ARM));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int unsigned EXP_OFFSET = 0,
   localparam int unsigned CW        = EXP_MAX - EXP_OFFSET
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic              run,
   input  logic              clr,
   output logic              tmo,
   output logic              win_open,
   output logic [CW-1:0]     cnt_q
);

   localparam int unsigned NTAB = 1 << RATE_W;

   logic [CW-1:0] last_tab [0:NTAB-1];
   logic [CW-1:0] wst_tab  [0:NTAB-1];

   assign last_tab[0] = '0;
   assign wst_tab[0]  = '0;

   // per-rate terminal count and window start; the window start is
   // three quarters of the period, formed by a shift
   for (genvar g = 1; g < NTAB; g++) begin : g_rate
      localparam int unsigned E = rate_exp(g) - EXP_OFFSET;
      assign last_tab[g] = CW'((64'd1 << E) - 64'd1);
      assign wst_tab[g]  = CW'(64'd3 << (E - 2));
   end

   logic [CW-1:0] last_sel;
   logic [CW-1:0] wst_sel;

   assign last_sel = last_tab[rate];
   assign wst_sel  = wst_tab[rate];
   assign tmo      = run && (cnt_q == last_sel);
   assign win_open = (cnt_q >= wst_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || tmo) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: the count never passes the terminal value of the live rate
   a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (rate != '0) |-> (cnt_q <= last_sel));

   // R6: with no clear and no run the count is held
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !run) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_win.sv
module wdog_win
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned CTRL_ADDR  = 0,
   parameter int unsigned SVC_ADDR   = 1,
   parameter int unsigned EXP_OFFSET = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              special_mode,
   input  logic              dbg_active,
   output logic              rst_req
);

   localparam int unsigned CW = EXP_MAX - EXP_OFFSET;

   if (EXP_OFFSET > 12) begin : g_bad_offset
      $error("EXP_OFFSET must leave every exponent at 2 or more");
   end
   if (CTRL_ADDR == SVC_ADDR) begin : g_bad_map
      $error("control and service registers need distinct addresses");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || SVC_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register address does not fit ADDR_W");
   end

   logic              ctrl_wr;
   logic              svc_wr;
   logic              win_en;
   logic              frz_en;
   logic [RATE_W-1:0] rate;
   logic              rate_wr;
   logic              run;
   logic              win_ok;
   logic              win_open;
   logic              tmo;
   logic              restart;
   logic              fault;
   logic              clr;
   logic [CW-1:0]     cnt_q;

   assign ctrl_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign svc_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(SVC_ADDR));

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_sel && !bus_we && bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata[WIN_BIT]       = win_en;
         bus_rdata[FRZ_BIT]       = frz_en;
         bus_rdata[RATE_W-1:0]    = rate;
      end
   end

   wdog_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ctrl_wr),
      .wdata   (bus_wdata),
      .special (special_mode),
      .win_en  (win_en),
      .frz_en  (frz_en),
      .rate    (rate),
      .rate_wr (rate_wr)
   );

   assign run    = (rate != '0) && !(frz_en && dbg_active);
   assign win_ok = !win_en || (rate == '0) || win_open;
   assign clr    = rate_wr || restart || fault;

   wdog_svc_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (svc_wr),
      .wdata   (bus_wdata),
      .win_ok  (win_ok),
      .tmo     (tmo),
      .restart (restart),
      .fault   (fault)
   );

   wdog_counter #(.EXP_OFFSET(EXP_OFFSET)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate     (rate),
      .run      (run),
      .clr      (clr),
      .tmo      (tmo),
      .win_open (win_open),
      .cnt_q    (cnt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
      end else begin
         rst_req <= tmo || fault;
      end
   end

   // R7: the count is zero in the cycle the request is visible
   a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt_q == '0));

   // R9: a stray service value always produces a request
   a_r9_bad_value: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && bus_wdata != KEY_ARM && bus_wdata != KEY_FIRE) |=> rst_req);

   // R10: an early write in window mode always produces a request
   a_r10_early: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && win_en && rate != '0 && !win_open) |=> rst_req);

endmodule

// File: tb/wdog_win_tb.sv
module wdog_win_tb;

   localparam int CLK_PERIOD = 10;
   localparam int OFF        = 10;
   localparam int AW         = 4;
   localparam logic [AW-1:0] A_CTRL = 4'd0;
   localparam logic [AW-1:0] A_SVC  = 4'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          special = 1'b0;
   logic          dbg = 1'b0;
   logic          rst_req;

   int n_cmp = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) pulses <= pulses + int'(rst_req);

   wdog_win #(.ADDR_W(AW), .CTRL_ADDR(0), .SVC_ADDR(1), .EXP_OFFSET(OFF)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (sel),
      .bus_we       (we),
      .bus_addr     (addr),
      .bus_wdata    (wdata),
      .bus_rdata    (rdata),
      .special_mode (special),
      .dbg_active   (dbg),
      .rst_req      (rst_req)
   );

   function automatic int period(input int code);
      int e;
      case (code)
         1: e = 14;  2: e = 16;  3: e = 18;  4: e = 20;
         5: e = 22;  6: e = 23;  default: e = 24;
      endcase
      return 1 << (e - OFF);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sel = 1'b0; we = 1'b0; special = 1'b0; dbg = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output int v);
      sel = 1'b1; we = 1'b0; addr = a;
      #1;
      v = int'(rdata);
      sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // from a falling edge just after the count was zeroed
   task automatic check_period(input string req, input int p);
      int base;
      int carry;
      carry = int'(rst_req);
      base  = pulses;
      idle(p - 1);
      chk(req, pulses - base, carry);
      chk(req, int'(rst_req), 0);
      idle(1);
      chk(req, int'(rst_req), 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int v;
      int base;

      // R1: reset state, rate 0 never fires
      do_reset();
      rd(A_CTRL, v);
      chk("R1 ctrl after reset", v, 8'h00);
      chk("R1 rst_req after reset", int'(rst_req), 0);
      base = pulses;
      idle(300);
      chk("R1 disabled no request", pulses - base, 0);

      // R2 layout and R4/R5 in special mode
      do_reset();
      special = 1'b1;
      wr(A_CTRL, 8'hFF);
      rd(A_CTRL, v);
      chk("R2 field layout", v, 8'hC7);
      rd(A_SVC, v);
      chk("R2 service reads zero", v, 8'h00);
      wr(A_CTRL, 8'h03);
      rd(A_CTRL, v);
      chk("R4 special rewrite / R5 freeze kept", v, 8'h43);
      wr(A_CTRL, 8'h05);
      rd(A_CTRL, v);
      chk("R4 special second rewrite", v, 8'h45);

      // R4/R5 in user mode
      do_reset();
      wr(A_CTRL, 8'h01);
      wr(A_CTRL, 8'hC3);
      rd(A_CTRL, v);
      chk("R4 user write-once / R5 freeze once", v, 8'h01);

      // R3 and R7: every rate, two consecutive timeouts
      for (int r = 1; r <= 7; r++) begin
         do_reset();
         wr(A_CTRL, 8'(r));
         check_period("R3 timeout", period(r));
         check_period("R7 periodic single pulse", period(r));
         idle(1);
         chk("R7 pulse is one cycle", int'(rst_req), 0);
      end

      // R8: repeated 0x55 then 0xAA restarts
      do_reset();
      wr(A_CTRL, 8'h02);
      idle(40);
      wr(A_SVC, 8'h55);
      wr(A_SVC, 8'h55);
      wr(A_SVC, 8'h55);
      chk("R8 arm no request", int'(rst_req), 0);
      wr(A_SVC, 8'hAA);
      chk("R8 fire no request", int'(rst_req), 0);
      check_period("R8 restart from zero", period(2));

      // R9 stray value, lone 0xAA; R11 0xAA after fault
      do_reset();
      wr(A_CTRL, 8'h07);
      wr(A_SVC, 8'h12);
      chk("R9 stray value", int'(rst_req), 1);
      idle(1);
      chk("R7 fault pulse one cycle", int'(rst_req), 0);
      wr(A_SVC, 8'hAA);
      chk("R9 lone 0xAA", int'(rst_req), 1);
      idle(2);
      wr(A_SVC, 8'h55);
      chk("R11 arm ok", int'(rst_req), 0);
      wr(A_SVC, 8'h3C);
      chk("R9 stray after arm", int'(rst_req), 1);
      idle(1);
      wr(A_SVC, 8'hAA);
      chk("R11 tracker idle after fault", int'(rst_req), 1);

      // R10 window boundaries (period 64, window from 48)
      do_reset();
      wr(A_CTRL, 8'h82);
      idle(47);
      wr(A_SVC, 8'h55);
      chk("R10 write at count 47 faults", int'(rst_req), 1);
      idle(48);
      wr(A_SVC, 8'h55);
      chk("R10 write at count 48 accepted", int'(rst_req), 0);
      wr(A_SVC, 8'hAA);
      chk("R10 fire in window accepted", int'(rst_req), 0);
      wr(A_SVC, 8'h55);
      chk("R10 early after restart faults", int'(rst_req), 1);
      check_period("R10 period after fault", period(2));

      // R6 freeze with freeze bit set (period 16)
      do_reset();
      wr(A_CTRL, 8'h41);
      idle(5);
      dbg = 1'b1;
      base = pulses;
      idle(100);
      chk("R6 frozen no request", pulses - base, 0);
      dbg = 1'b0;
      idle(10);
      chk("R6 held count resumes", int'(rst_req), 0);
      idle(1);
      chk("R6 resume timeout", int'(rst_req), 1);

      // R6 freeze bit clear: debug input ignored
      do_reset();
      wr(A_CTRL, 8'h01);
      dbg = 1'b1;
      check_period("R6 no freeze when bit clear", period(1));
      dbg = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule